// File: doc/BRIEF.md
# Two-Stage (2-1) Digital Noise-Shaping Modulator

This block reduces a signed fixed-point sample stream to a small odd-valued signed word per sample while pushing the quantization noise toward high frequencies with a third-order shape. It is built from two one-bit loops in cascade. The front loop is second order and quantizes the input sample itself. The back loop is first order and quantizes the front loop's residual error. A digital combiner then merges the two one-bit streams so that the front loop's error drops out and only the back loop's error remains, shaped by (1 - z^-1)^3.

Both loops use an error-feedback form, so the quantity handed to the back loop is exactly the one the front loop's noise transfer acts on, and the combiner cancels it bit for bit. A sample is consumed on each clock where the enable is high; with the enable low everything holds. The combined word is registered and appears one clock after the enabling edge. The full-scale unit F is 2^(IN_W-1). The front loop's stored error saturates so that no accumulator can wrap, and the back loop's quantizer level is sized so that its own error is bounded by design.

Top module: `mash21_top`

## Requirements
- R1: A synchronous active-high reset clears every stored error and every history register to zero and drives `dout` to 0, `s1_bit` to 0 and `s2_bit` to 0.
- R2: When `en` is high at a rising clock edge, the sample on `din` is consumed and `dout`, `s1_bit` and `s2_bit` show the result for that sample right after that same edge (one register of latency).
- R3: When `en` is low at a rising edge, all stored errors, histories and the three outputs keep their values.
- R4: The front loop forms v1 = x + 2*e1[n-1] - e1[n-2]; its decision is +1 (reported as `s1_bit` = 1) when v1 >= 0 and -1 (`s1_bit` = 0) otherwise, so a zero value decides +1.
- R5: The front loop's error is v1 minus its decision times F, saturated to the range -2F..+2F before it is stored and before it is passed on.
- R6: The back loop forms v2 = e1 + e2[n-1], decides +1 (`s2_bit` = 1) for v2 >= 0 and -1 (`s2_bit` = 0) otherwise, with decision level 2F; its stored error e2 = v2 minus decision times 2F always stays within -2F..+2F.
- R7: `dout` (5-bit two's complement) equals y1 + 2*(y2[n] - 2*y2[n-1] + y2[n-2]) with y1, y2 in {-1,+1} and histories zero after reset; every produced value is odd and lies in -9..+9.
- R8: While the saturation of R5 has not acted on the current or two previous samples, F*dout[n] equals x[n] minus the third difference e2[n] - 3e2[n-1] + 3e2[n-2] - e2[n-3].
- R9: Over any run from reset without saturation, the sum of dout times F differs from the sum of the inputs by at most 16F.
- R10: The first sample after reset with `din` = 0 yields `dout` = -1, `s1_bit` = 1 and `s2_bit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable: consume `din` on this edge |
| din | input | IN_W | Signed input sample, full scale F = 2^(IN_W-1) |
| dout | output | 5 | Signed combined output word, odd, -9..+9 |
| s1_bit | output | 1 | Front loop decision of the last sample (1 means +1) |
| s2_bit | output | 1 | Back loop decision of the last sample (1 means +1) |

## Verification
The bench runs its own integer model of both loops and the combiner and compares all three outputs after every enabled edge, so a wrong feedback coefficient, an inverted tie decision or a swapped history tap shows up as a diverging bit stream within a few samples. The zero-input first sample after reset targets the tie rule and the zeroed histories; a design that decided -1 on zero, or preloaded the histories with -1, would not produce -1 there. The third-difference identity and the DC sum bound catch a combiner whose weighting or delay does not match the loops, which would leave front-loop error in the output and make the sums drift. Full-scale inputs drive the saturation path, and gaps in the enable confirm that nothing moves while idle.

// File: rtl/mash21_pkg.sv
package mash21_pkg;

    // Combined output word: y1 + 2 * second difference of y2 spans -9..+9.
    localparam int OUT_W  = 5;
    // Depth of the back-loop decision history used by the combiner.
    localparam int HIST_D = 2;

    typedef logic signed [OUT_W-1:0] mash_word_t;
    typedef logic signed [1:0]       pm_t;

    // Decisions of both loops for one sample.
    typedef struct packed {
        logic front_hi;
        logic back_hi;
    } mash_bits_t;

    // Map a decision bit to +1 / -1.
    function automatic pm_t pm_of(input logic hi);
        return hi ? 2'sd1 : -2'sd1;
    endfunction

endpackage

// File: rtl/mash21_loop2.sv
module mash21_loop2 #(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W-1:0] x_i,
    output logic                   hi_o,
    output logic signed [IN_W+1:0] err_o
);
    localparam int EW = IN_W + 2;
    localparam int VW = IN_W + 4;
    localparam logic signed [VW-1:0] FS  = VW'(1) <<< (IN_W - 1);
    localparam logic signed [VW-1:0] LIM = FS <<< 1;

    logic signed [EW-1:0] e_d1, e_d2;
    logic signed [VW-1:0] v_acc, resid;

    always_comb begin
        v_acc = VW'(x_i) + (VW'(e_d1) <<< 1) - VW'(e_d2);
        hi_o  = !v_acc[VW-1];
        resid = hi_o ? (v_acc - FS) : (v_acc + FS);
        if (resid > LIM)
            err_o = EW'(LIM);
        else if (resid < -LIM)
            err_o = EW'(-LIM);
        else
            err_o = EW'(resid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_d1 <= '0;
            e_d2 <= '0;
        end else if (en) begin
            e_d1 <= err_o;
            e_d2 <= e_d1;
        end
    end

    // R5: the stored front error never leaves the saturated window
    assert_front_err_window_R5: assert property (@(posedge clk) disable iff (rst)
        (VW'(e_d1) <= LIM) && (VW'(e_d1) >= -LIM) && (VW'(e_d2) <= LIM) && (VW'(e_d2) >= -LIM));

endmodule

// File: rtl/mash21_loop1.sv
module mash21_loop1 #(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W+1:0] u_i,
    output logic                   hi_o
);
    localparam int EW = IN_W + 2;
    localparam int VW = IN_W + 4;
    localparam logic signed [VW-1:0] LVL = VW'(1) <<< IN_W;

    logic signed [EW-1:0] e_d1;
    logic signed [VW-1:0] v_acc, resid;

    always_comb begin
        v_acc = VW'(u_i) + VW'(e_d1);
        hi_o  = !v_acc[VW-1];
        resid = hi_o ? (v_acc - LVL) : (v_acc + LVL);
    end

    always_ff @(posedge clk) begin
        if (rst)
            e_d1 <= '0;
        else if (en)
            e_d1 <= EW'(resid);
    end

    // R6: back-loop error is bounded by its decision level
    assert_back_err_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        (VW'(e_d1) <= LVL) && (VW'(e_d1) >= -LVL));

endmodule

// File: rtl/mash21_combine.sv
module mash21_combine
    import mash21_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  mash_bits_t bits_i,
    output mash_word_t word_o,
    output logic       s1_o,
    output logic       s2_o
);
    pm_t        y2_h [HIST_D];
    mash_word_t a1, a2, h1, h2, sum_w;

    always_comb begin
        a1    = OUT_W'(pm_of(bits_i.front_hi));
        a2    = OUT_W'(pm_of(bits_i.back_hi));
        h1    = OUT_W'(y2_h[0]);
        h2    = OUT_W'(y2_h[HIST_D-1]);
        sum_w = a1 + ((a2 - (h1 <<< 1) + h2) <<< 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            s1_o   <= 1'b0;
            s2_o   <= 1'b0;
            for (int k = 0; k < HIST_D; k++) y2_h[k] <= '0;
        end else if (en) begin
            word_o  <= sum_w;
            s1_o    <= bits_i.front_hi;
            s2_o    <= bits_i.back_hi;
            y2_h[0] <= pm_of(bits_i.back_hi);
            for (int k = 1; k < HIST_D; k++) y2_h[k] <= y2_h[k-1];
        end
    end

    // R1: reset leaves the outputs at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (word_o == '0) && !s1_o && !s2_o);

    // R3: idle edges change nothing visible
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word_o) && $stable(s1_o) && $stable(s2_o));

    // R7: every produced word is odd
    assert_word_odd_R7: assert property (@(posedge clk) disable iff (rst)
        en |=> word_o[0]);

    // R7: word stays inside -9..+9
    assert_word_range_R7: assert property (@(posedge clk) disable iff (rst)
        (word_o <= 5'sd9) && (word_o >= -5'sd9));

endmodule

// File: rtl/mash21_top.sv
module mash21_top
    import mash21_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout,
    output logic                    s1_bit,
    output logic                    s2_bit
);
    logic                   front_hi, back_hi;
    logic signed [IN_W+1:0] front_err;
    mash_bits_t             bits;

    mash21_loop2 #(.IN_W(IN_W)) u_front (
        .clk(clk), .rst(rst), .en(en),
        .x_i(din), .hi_o(front_hi), .err_o(front_err)
    );

    mash21_loop1 #(.IN_W(IN_W)) u_back (
        .clk(clk), .rst(rst), .en(en),
        .u_i(front_err), .hi_o(back_hi)
    );

    assign bits = '{front_hi: front_hi, back_hi: back_hi};

    mash21_combine u_comb (
        .clk(clk), .rst(rst), .en(en),
        .bits_i(bits), .word_o(dout), .s1_o(s1_bit), .s2_o(s2_bit)
    );

endmodule

// File: tb/mash21_top_tb_top.sv
module mash21_top_tb_top;
    localparam int  W  = 16;
    localparam longint F = longint'(1) << (W - 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                en  = 1'b0;
    logic signed [W-1:0] din = '0;
    logic signed [4:0]   dout;
    logic                s1_bit, s2_bit;

    int checks = 0;
    int errors = 0;

    // reference state
    longint m_e1a, m_e1b, m_e2a, m_e2b, m_e2c;
    int     m_y2a, m_y2b;
    int     exp_out;
    bit     exp_s1, exp_s2;
    bit     cl0, cl1, cl2;
    longint sum_x, sum_o;
    bit     seg_clamped;
    int unsigned lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    mash21_top #(.IN_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .din(din),
        .dout(dout), .s1_bit(s1_bit), .s2_bit(s2_bit)
    );

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int unsigned nxt(input int unsigned s);
        int unsigned t = s;
        t ^= t << 13; t ^= t >> 17; t ^= t << 5;
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_clear();
        m_e1a = 0; m_e1b = 0; m_e2a = 0; m_e2b = 0; m_e2c = 0;
        m_y2a = 0; m_y2b = 0; exp_out = 0; exp_s1 = 0; exp_s2 = 0;
        cl0 = 0; cl1 = 0; cl2 = 0; sum_x = 0; sum_o = 0; seg_clamped = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; en = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        model_clear();
        chk(dout == 0, "R1 dout", dout, 0);
        chk(s1_bit == 0 && s2_bit == 0, "R1 bits", {s1_bit, s2_bit}, 0);
    endtask

    // one clock; when e is set the model advances and all outputs are compared
    task automatic step(input longint x, input bit e);
        longint v1, r, e1, v2, e2n;
        int y1, y2;
        din = W'(x);
        en  = e;
        @(posedge clk); #1;
        if (e) begin
            v1 = x + 2 * m_e1a - m_e1b;
            y1 = (v1 >= 0) ? 1 : -1;
            r  = v1 - y1 * F;
            cl2 = cl1; cl1 = cl0;
            cl0 = (r > 2 * F) || (r < -2 * F);
            if (cl0) seg_clamped = 1;
            e1 = (r > 2 * F) ? 2 * F : ((r < -2 * F) ? -2 * F : r);
            v2 = e1 + m_e2a;
            y2 = (v2 >= 0) ? 1 : -1;
            e2n = v2 - y2 * 2 * F;
            exp_out = y1 + 2 * (y2 - 2 * m_y2a + m_y2b);
            exp_s1 = (y1 > 0);
            exp_s2 = (y2 > 0);
            // R8: cancellation identity on the actual output
            if (!cl0 && !cl1 && !cl2)
                chk(F * longint'(dout) == x - (e2n - 3 * m_e2a + 3 * m_e2b - m_e2c),
                    "R8 cancel", F * longint'(dout), x - (e2n - 3 * m_e2a + 3 * m_e2b - m_e2c));
            sum_x += x;
            sum_o += longint'(dout);
            m_e1b = m_e1a; m_e1a = e1;
            m_e2c = m_e2b; m_e2b = m_e2a; m_e2a = e2n;
            m_y2b = m_y2a; m_y2a = y2;
        end
        // R2 R4 R5 R6 R7 on enabled edges; R3 hold on idle edges
        chk(int'(dout) == exp_out, e ? "R7 word" : "R3 hold word", dout, exp_out);
        chk(s1_bit == exp_s1, e ? "R4 front bit" : "R3 hold s1", s1_bit, exp_s1);
        chk(s2_bit == exp_s2, e ? "R6 back bit" : "R3 hold s2", s2_bit, exp_s2);
    endtask

    task automatic dc_check();
        longint d = sum_o * F - sum_x;
        if (!seg_clamped)
            chk(d <= 16 * F && d >= -16 * F, "R9 dc sum", d, 0);
    endtask

    initial begin
        model_clear();
        do_reset();

        // R10 and R2: first zero sample after reset
        step(0, 1);
        chk(dout == -1 && s1_bit == 1 && s2_bit == 0, "R10 first sample", dout, -1);
        do_reset();

        // positive DC
        for (int i = 0; i < 2000; i++) step(F / 4, 1);
        dc_check();
        do_reset();

        // negative DC
        for (int i = 0; i < 2000; i++) step(-(3 * F) / 8, 1);
        dc_check();
        do_reset();

        // triangle sweep within half scale
        begin
            longint t = 0;
            longint dir = 256;
            for (int i = 0; i < 1500; i++) begin
                step(t, 1);
                t += dir;
                if (t >= F / 2 || t <= -F / 2) dir = -dir;
            end
        end
        dc_check();

        // R3: random samples with random idle gaps, idle din changing
        for (int i = 0; i < 1500; i++) begin
            lfsr = nxt(lfsr);
            step(longint'($signed(lfsr[31:16])) / 4, lfsr[3] | lfsr[7]);
        end
        do_reset();

        // R5: full-scale drive forces saturation paths
        for (int i = 0; i < 300; i++) step(F - 1, 1);
        for (int i = 0; i < 300; i++) step(-F, 1);
        for (int i = 0; i < 300; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0] ? F - 1 : -F, 1);
        end

        // R1: reset in mid-run, then restart
        do_reset();
        for (int i = 0; i < 200; i++) step(F / 8, 1);
        dc_check();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule